// File: doc/BRIEF.md
# Segment LCD Blink-Enable Memory

This block holds one blink-enable bit for every segment position of a segment LCD controller. Its byte layout matches the controller's segment memory: each byte carries two segments, and each nibble holds the bits for common lines 0 to 3 of one segment. Software reaches the bits over a small bus with a byte address, a write strobe, two byte-lane strobes and 16-bit write and read data, so a single access can read or write one byte or an aligned pair of bytes.

The display timing logic supplies the index of the segment position currently being driven, the active multiplex mode and a one-cycle frame-boundary strobe. The block returns the blink-enable bit for that position. The bit is gated to zero when the position's common line is not used in the current mode, and for every mode above 4-mux. A control bit asks for every blink byte to be erased. The erase waits for the next frame-boundary strobe, and the control bit then drops by itself.

The block is meant to sit beside the segment memory. A blink divider elsewhere decides when the enabled segments actually turn off.

Top module: `seg_blink_mem`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every blink byte and the pending erase request become 0. The reset is synchronous.
- R2: A write to an even address with `bus_be[0]` set stores `bus_wdata[7:0]` in that byte. With `bus_be[1]` set it stores `bus_wdata[15:8]` in the next byte. The new value is readable after the capturing edge.
- R3: A write to an odd address with `bus_be` = 2'b10 stores `bus_wdata[15:8]` in that one byte. Any other strobe pattern at an odd address, including 2'b11, changes nothing.
- R4: `bus_rdata` is combinational. `[7:0]` returns the byte at `bus_addr` with bit 0 cleared, and `[15:8]` returns the byte at that address plus one. Addresses 21 to 31 read 0.
- R5: Byte address 20 is the control byte, and its bit 0 is the erase request. Writing 1 there with `bus_be[0]` set raises the request. Writing 0 has no effect. The request reads back as 1 while it is pending.
- R6: A pending erase leaves the blink bytes untouched until the clock edge at which `frame_tick` is 1. At that edge every blink byte becomes 0.
- R7: The request drops to 0 at the edge that performs the erase. A new request written in that same cycle stays pending. A `frame_tick` with no request pending changes nothing.
- R8: When a data write and an erase land on the same edge, the erase wins and the written byte ends as 0.
- R9: `blink_en` is bit `seg_sel[2:0]` of byte `seg_sel[7:3]`. `seg_sel[1:0]` is the common index. Mode codes on `mux_mode` are 0 static, 1 2-mux, 2 3-mux and 3 4-mux. The output is the stored bit only when the common index is no greater than the mode code; otherwise it is 0.
- R10: In 3-mux mode, common index 3 never drives `blink_en`, yet its stored bit still reads back over the bus.
- R11: For `mux_mode` 4 to 7, `blink_en` is 0 whatever is stored.
- R12: For `seg_sel` of 160 or more, `blink_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte-lane strobes; lane 0 is the low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the aligned byte pair |
| frame_tick | input | 1 | One-cycle frame-boundary strobe |
| mux_mode | input | 3 | Multiplex mode code |
| seg_sel | input | 8 | Segment position being driven |
| blink_en | output | 1 | Blink enable for that position |

## Verification
Each result has a fixed due time:
- A write or an erase takes effect at the rising edge that captures it.
- `bus_rdata` and `blink_en` follow their inputs with no clock in between.

The bench keeps to this timing. It drives every input on the falling edge. It samples combinational results one nanosecond after changing the selecting inputs. It checks state changes at the falling edge that follows the capturing rising edge. For the erase, it checks the stored bytes during several idle cycles before the strobe and again at the falling edge right after the strobe's edge.

// File: rtl/seg_blink_pkg.sv
// Shared constants and helpers for the blink-enable memory.
// Assumes the nibble layout: bit k of a nibble belongs to common line k.
package seg_blink_pkg;
    localparam int BYTE_W      = 8;
    localparam int MAX_COMMONS = 4;

    // Mode codes carried on mux_mode; codes above MODE_MUX4 mean higher multiplex modes.
    localparam logic [2:0] MODE_STATIC = 3'd0;
    localparam logic [2:0] MODE_MUX2   = 3'd1;
    localparam logic [2:0] MODE_MUX3   = 3'd2;
    localparam logic [2:0] MODE_MUX4   = 3'd3;

    // True when common line com is driven in the given mode and blinking applies there.
    function automatic logic common_in_use(input logic [2:0] mode, input logic [1:0] com);
        return (mode <= MODE_MUX4) && ({1'b0, com} <= mode);
    endfunction
endpackage

// File: rtl/seg_blink_decode.sv
// Bus write decoder.
// Turns one bus write into per-byte write enables, plus the set pulse for the erase request.
// Assumes: even bytes take the low data lane and odd bytes take the high lane.
// A write to an odd address is accepted only with the high-lane strobe alone.
// CTRL_ADDR is even and lies outside the blink byte range.
module seg_blink_decode #(
    parameter int NUM_BYTES = 20,
    parameter int ADDR_W    = 5,
    parameter int CTRL_ADDR = 20
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    input  logic [1:0]           be,
    input  logic [15:0]          wdata,
    output logic [NUM_BYTES-1:0] byte_we,
    output logic [7:0]           lo_data,
    output logic [7:0]           hi_data,
    output logic                 req_set
);
    localparam int PW = ADDR_W - 1;

    logic wr_ok;

    // Qualify the write: an odd address accepts only a lone high-lane strobe.
    assign wr_ok   = wr && (!addr[0] || (be == 2'b10));
    assign lo_data = wdata[7:0];
    assign hi_data = wdata[15:8];

    // Raise the erase request when bit 0 of the control byte is written with 1.
    assign req_set = wr && (addr == ADDR_W'(CTRL_ADDR)) && be[0] && wdata[0];

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_we
        // Enable this byte when its pair is addressed and its own lane strobe is set.
        assign byte_we[i] = wr_ok && (addr[ADDR_W-1:1] == PW'(i / 2)) && be[i % 2];
    end
endmodule

// File: rtl/seg_blink_store.sv
// Blink byte storage.
// One register byte per entry, with a synchronous active-low reset and an erase that clears all bytes.
// Assumes the erase has priority over any write in the same cycle.
module seg_blink_store #(
    parameter int NUM_BYTES = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_BYTES-1:0]   byte_we,
    input  logic [7:0]             lo_data,
    input  logic [7:0]             hi_data,
    input  logic                   erase_now,
    output logic [NUM_BYTES*8-1:0] mem_bits
);
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        logic [7:0] wval;
        if ((i % 2) == 1) begin : g_hi
            assign wval = hi_data;
        end else begin : g_lo
            assign wval = lo_data;
        end

        // Hold one blink byte: cleared by reset or erase, otherwise loaded on its enable.
        always_ff @(posedge clk) begin
            if (!rst_n || erase_now) begin
                mem_bits[i*8 +: 8] <= '0;
            end else if (byte_we[i]) begin
                mem_bits[i*8 +: 8] <= wval;
            end
        end
    end
endmodule

// File: rtl/seg_blink_clr.sv
// Deferred erase control.
// Keeps the erase request pending until a frame strobe arrives.
// The erase is issued on that strobe and the request then drops by itself.
// Assumes a new request in the completion cycle is kept pending rather than lost.
module seg_blink_clr (
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic frame_tick,
    output logic pending,
    output logic erase_now
);
    // Erase fires only when a request is already pending at the strobe.
    assign erase_now = pending && frame_tick;

    // Track the request: a fresh set wins over completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (req_set) begin
            pending <= 1'b1;
        end else if (erase_now) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/seg_blink_rdmux.sv
// Read data multiplexer.
// Returns the aligned byte pair selected by the pair index.
// Unmapped bytes read 0. The control pair shows the pending erase request in bit 0.
module seg_blink_rdmux #(
    parameter int NUM_BYTES = 20,
    parameter int ADDR_W    = 5,
    parameter int CTRL_ADDR = 20
) (
    input  logic [ADDR_W-2:0]      pair_idx,
    input  logic [NUM_BYTES*8-1:0] mem_bits,
    input  logic                   pending,
    output logic [15:0]            rdata
);
    localparam int PW = ADDR_W - 1;

    // Gather the two bytes of the addressed pair into the read lanes.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (pair_idx == PW'(i / 2)) begin
                if ((i % 2) == 1) begin
                    rdata[15:8] = mem_bits[i*8 +: 8];
                end else begin
                    rdata[7:0] = mem_bits[i*8 +: 8];
                end
            end
        end
        if (pair_idx == PW'(CTRL_ADDR / 2)) begin
            rdata[0] = pending;
        end
    end
endmodule

// File: rtl/seg_blink_sel.sv
// Segment blink selector.
// Picks the stored bit for the segment position being driven, and gates it by the multiplex mode.
// Assumes the low two bits of the position give the common line.
module seg_blink_sel #(
    parameter int NUM_SEGS = 160,
    parameter int SEG_W    = 8
) (
    input  logic [NUM_SEGS-1:0] mem_bits,
    input  logic [2:0]          mux_mode,
    input  logic [SEG_W-1:0]    seg_sel,
    output logic                blink_en
);
    import seg_blink_pkg::*;

    logic             in_range;
    logic [SEG_W-1:0] safe_idx;

    // Reject positions beyond the stored range and keep the bit index inside the vector.
    assign in_range = ({1'b0, seg_sel} < (SEG_W + 1)'(NUM_SEGS));
    assign safe_idx = in_range ? seg_sel : '0;

    // Drive the stored bit only for positions whose common line is in use.
    assign blink_en = in_range && common_in_use(mux_mode, seg_sel[1:0]) && mem_bits[safe_idx];
endmodule

// File: rtl/seg_blink_mem.sv
// Blink-enable memory top.
// Byte and word bus access, deferred erase on the frame strobe, and a mode-gated per-segment output.
// Assumes CTRL_ADDR is even and at least NUM_BYTES. The reset is synchronous and active low.
module seg_blink_mem #(
    parameter int NUM_BYTES = 20,
    parameter int ADDR_W    = 5,
    parameter int CTRL_ADDR = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              frame_tick,
    input  logic [2:0]        mux_mode,
    input  logic [7:0]        seg_sel,
    output logic              blink_en
);
    localparam int NUM_SEGS = NUM_BYTES * seg_blink_pkg::BYTE_W;
    localparam int SEG_W    = $clog2(NUM_SEGS);

    logic [NUM_BYTES-1:0]   byte_we;
    logic [7:0]             lo_data;
    logic [7:0]             hi_data;
    logic                   req_set;
    logic                   clr_pending;
    logic                   erase_now;
    logic [NUM_SEGS-1:0]    mem_bits;

    seg_blink_decode #(
        .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_decode (
        .addr(bus_addr), .wr(bus_wr), .be(bus_be), .wdata(bus_wdata),
        .byte_we(byte_we), .lo_data(lo_data), .hi_data(hi_data), .req_set(req_set)
    );

    seg_blink_clr u_clr (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .frame_tick(frame_tick),
        .pending(clr_pending), .erase_now(erase_now)
    );

    seg_blink_store #(.NUM_BYTES(NUM_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .lo_data(lo_data),
        .hi_data(hi_data), .erase_now(erase_now), .mem_bits(mem_bits)
    );

    seg_blink_rdmux #(
        .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_rdmux (
        .pair_idx(bus_addr[ADDR_W-1:1]), .mem_bits(mem_bits),
        .pending(clr_pending), .rdata(bus_rdata)
    );

    seg_blink_sel #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W)) u_sel (
        .mem_bits(mem_bits), .mux_mode(mux_mode), .seg_sel(seg_sel[SEG_W-1:0]),
        .blink_en(blink_en)
    );
endmodule

// File: rtl/seg_blink_mem_chk.sv
// Property checker for the blink-enable memory, attached to the top by bind.
// Observes the bus ports, the stored bits and the pending erase request.
module seg_blink_mem_chk #(
    parameter int NUM_BYTES = 20,
    parameter int ADDR_W    = 5,
    parameter int CTRL_ADDR = 20
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_wr,
    input logic [1:0]             bus_be,
    input logic                   wdata_b0,
    input logic                   frame_tick,
    input logic [2:0]             mux_mode,
    input logic [7:0]             seg_sel,
    input logic                   blink_en,
    input logic [NUM_BYTES*8-1:0] mem_bits,
    input logic                   pending
);
    logic ctrl_set;
    assign ctrl_set = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR)) && bus_be[0] && wdata_b0;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (mem_bits == '0) && !pending);

    // R6
    erase_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending && frame_tick |=> (mem_bits == '0));

    // R6
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick && !bus_wr |=> $stable(mem_bits));

    // R7
    request_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending && frame_tick && !ctrl_set |=> !pending);

    // R5
    request_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !frame_tick |=> pending);

    // R3
    odd_word_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr[0] && (bus_be != 2'b10) && !frame_tick |=> $stable(mem_bits));

    // R11
    high_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode > 3'd3) |-> !blink_en);

    // R10
    mux3_fourth_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode == 3'd2) && (seg_sel[1:0] == 2'd3) |-> !blink_en);

    // R12
    range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_sel >= 8'(NUM_BYTES * 8)) |-> !blink_en);
endmodule

bind seg_blink_mem seg_blink_mem_chk #(
    .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .wdata_b0(bus_wdata[0]), .frame_tick(frame_tick), .mux_mode(mux_mode),
    .seg_sel(seg_sel), .blink_en(blink_en), .mem_bits(mem_bits), .pending(clr_pending)
);

// File: tb/seg_blink_mem_bench.sv
// Directed bench for the blink-enable memory. One task per scenario, each checking its own results.
module seg_blink_mem_bench;
    localparam int NB    = 20;
    localparam int CTRL  = 20;
    localparam int CLK_P = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        frame_tick = 1'b0;
    logic [2:0]  mux_mode = '0;
    logic [7:0]  seg_sel = '0;
    logic        blink_en;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] model [NB];
    logic       model_pend = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    seg_blink_mem u_seg_blink_mem (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_tick(frame_tick),
        .mux_mode(mux_mode), .seg_sel(seg_sel), .blink_en(blink_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input int a);
        if (a < NB) return model[a];
        if (a == CTRL) return {7'b0, model_pend};
        return 8'h00;
    endfunction

    function automatic logic [15:0] exp_rd(input int a);
        int lo = a & ~1;
        return {mbyte(lo + 1), mbyte(lo)};
    endfunction

    function automatic logic exp_blink(input int mode, input int s);
        if (s >= NB * 8 || mode > 3 || (s % 4) > mode) return 1'b0;
        return model[s / 8][s % 8];
    endfunction

    // Model one data write following R2 and R3.
    function automatic void model_write(input int a, input logic [1:0] be, input logic [15:0] d);
        if ((a % 2) == 0) begin
            if (be[0] && a < NB) model[a] = d[7:0];
            if (be[1] && a + 1 < NB) model[a + 1] = d[15:8];
        end else if (be == 2'b10 && a < NB) begin
            model[a] = d[15:8];
        end
    endfunction

    task automatic bus_write(input int a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_addr = 5'(a); bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, be, d);
    endtask

    task automatic check_rd(input string tag, input int a);
        bus_addr = 5'(a);
        #1;
        check(tag, 32'(bus_rdata), 32'(exp_rd(a)));
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 32; a += 2) check_rd(tag, a);
    endtask

    task automatic fill(input int seed);
        for (int a = 0; a < NB; a += 2)
            bus_write(a, 2'b11, 16'((a * 16'h1D3B + seed * 16'h0A77) ^ 16'h5AC3));
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
        if (model_pend) begin
            for (int i = 0; i < NB; i++) model[i] = 8'h00;
            model_pend = 1'b0;
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < NB; i++) model[i] = 8'h00;
        model_pend = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 after reset");
        mux_mode = 3'd3; seg_sel = 8'd0; #1;
        check("R1 blink_en", 32'(blink_en), 32'd0);
        fill(3);
        bus_write(CTRL, 2'b01, 16'h0001); model_pend = 1'b1;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < NB; i++) model[i] = 8'h00;
        model_pend = 1'b0;
        check_all("R1 mid-run reset");
    endtask

    task automatic t_writes();
        fill(1);
        check_all("R2 word writes");
        bus_write(4, 2'b01, 16'hEE11);
        bus_write(6, 2'b10, 16'h77CC);
        check_all("R2 lane writes");
        check_rd("R4 odd read addr", 5);
        check_rd("R4 unmapped", 24);
        check_rd("R4 unmapped top", 31);
    endtask

    task automatic t_odd();
        bus_write(3, 2'b11, 16'hA5A5);
        check_all("R3 odd word ignored");
        bus_write(7, 2'b01, 16'h3C3C);
        check_all("R3 odd low lane ignored");
        bus_write(9, 2'b10, 16'h9600);
        check("R3 odd byte", 32'(model[9]), 32'h96);
        check_all("R3 odd byte only");
    endtask

    task automatic t_erase();
        fill(2);
        bus_write(CTRL, 2'b01, 16'h0001); model_pend = 1'b1;
        check_rd("R5 pending reads 1", CTRL);
        bus_write(CTRL, 2'b01, 16'h0000);
        check_rd("R5 write 0 no effect", CTRL);
        repeat (5) @(negedge clk);
        check_all("R6 held before strobe");
        pulse_frame();
        check_all("R6 erased at strobe");
        check_rd("R7 request dropped", CTRL);
        fill(4);
        pulse_frame();
        check_all("R7 strobe without request");
    endtask

    task automatic t_race();
        fill(5);
        bus_write(CTRL, 2'b01, 16'h0001); model_pend = 1'b1;
        @(negedge clk);
        frame_tick = 1'b1;
        bus_addr = 5'd4; bus_be = 2'b11; bus_wdata = 16'h1234; bus_wr = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0; bus_wr = 1'b0;
        for (int i = 0; i < NB; i++) model[i] = 8'h00;
        model_pend = 1'b0;
        check_all("R8 erase beats write");
        fill(6);
        bus_write(CTRL, 2'b01, 16'h0001); model_pend = 1'b1;
        @(negedge clk);
        frame_tick = 1'b1;
        bus_addr = 5'(CTRL); bus_be = 2'b01; bus_wdata = 16'h0001; bus_wr = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0; bus_wr = 1'b0;
        for (int i = 0; i < NB; i++) model[i] = 8'h00;
        check_all("R7 new request kept");
        pulse_frame();
        check_rd("R7 second erase done", CTRL);
    endtask

    task automatic t_select();
        fill(7);
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 256; s++) begin
                mux_mode = 3'(m); seg_sel = 8'(s);
                #1;
                check(m > 3 ? "R11 high mode" : (s >= NB * 8 ? "R12 range" : "R9 select"),
                      32'(blink_en), 32'(exp_blink(m, s)));
            end
        end
        bus_write(0, 2'b01, 16'h00FF);
        mux_mode = 3'd2;
        seg_sel = 8'd3; #1;
        check("R10 fourth common quiet", 32'(blink_en), 32'd0);
        seg_sel = 8'd2; #1;
        check("R10 third common drives", 32'(blink_en), 32'd1);
        check_rd("R10 stored bit readable", 0);
        mux_mode = 3'd0; seg_sel = 8'd1; #1;
        check("R9 static second common", 32'(blink_en), 32'd0);
        mux_mode = 3'd3; seg_sel = 8'd7; #1;
        check("R9 mux4 fourth common", 32'(blink_en), 32'd1);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_writes();
        t_odd();
        t_erase();
        t_race();
        t_select();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule